// File: doc/BRIEF.md
# Semaphore Interrupt Register Set

This block holds the two semaphore registers that pass event flags between a host processor and a coprocessor. One register carries flags outward: the host writes it, and the coprocessor sees the value on a flag output and can acknowledge individual bits with clear strobes. The other register carries flags inward: the coprocessor raises bits with set strobes, and the host reads them, masks them and clears them.

Every inward flag whose mask bit is 0 contributes to a single level-sensitive host interrupt. The same condition shows in bit 0 of a read-only status word. Masking uses active-high disable bits. A set flag is removed only by writing ones to a separate clear register, never by writing the flag register itself.

The host side is a single-cycle register bus. A write happens in the cycle `bus_we` is high. Read data is a combinational function of `bus_addr`. The coprocessor side has only plain strobes and levels, with no handshake and no back-pressure: every strobe takes effect in the cycle it is high.

Top module: `sem_irq_regs`

## Requirements
- R1: After reset the outward flags, inward flags and mask are all 0, `host_irq` is low and `cp_flags_o` is 0.
- R2: A host write to address 0 replaces the outward flags. From the next cycle, the new value reads back at address 0 and appears on `cp_flags_o`.
- R3: A 1 on a bit of `cp_ack` clears that outward flag on the next edge. If a host write to address 0 occurs in the same cycle, the written value is taken and the acknowledge is dropped.
- R4: A 1 on a bit of `cp_set` sets that inward flag, which reads back at address 1. Host writes to address 1 have no effect.
- R5: Writing to address 2 clears each inward flag whose data bit is 1 and leaves flags with a 0 data bit unchanged. Address 2 always reads as 0.
- R6: When `cp_set` and a clear write hit the same bit in the same cycle, the flag ends up set.
- R7: Address 3 is the read/write mask. A mask bit of 1 disables its flag's interrupt. `host_irq` is high exactly when some inward flag is set and its mask bit is 0.
- R8: Address 4 reads the status word: bit 0 equals `host_irq` and all other bits are 0. Addresses 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Host write strobe |
| bus_addr | input | 3 | Host register address |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data for `bus_addr` |
| cp_set | input | 16 | Coprocessor strobes that set inward flags |
| cp_ack | input | 16 | Coprocessor strobes that clear outward flags |
| cp_flags_o | output | 16 | Outward flags as seen by the coprocessor |
| host_irq | output | 1 | Host semaphore interrupt, level |

## Verification
The hardest case to reach is a collision on one bit: a coprocessor set and a host clear in the same edge, or a coprocessor acknowledge and a host write in the same edge. Only a bench that drives both sides in the same cycle reaches it. The vector table therefore gives each step both a host operation and coprocessor strobes, and it includes steps where the two overlap. The clear data also covers bits that are not being set, so the same step shows which bits were cleared and which were kept. The mask steps hold the flag pattern fixed and vary only the mask. As a result, the interrupt rises and falls without any flag changing.

// File: rtl/sem_pkg.sv
package sem_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_OUT  = 3'd0,
    A_IN   = 3'd1,
    A_CLR  = 3'd2,
    A_MASK = 3'd3,
    A_STAT = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic out_we;
    logic clr_we;
    logic mask_we;
  } wr_strobe_t;
endpackage

// File: rtl/sem_decode.sv
module sem_decode
  import sem_pkg::*;
(
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output wr_strobe_t        strobe
);
  always_comb begin
    strobe = '0;
    if (bus_we) begin
      case (bus_addr)
        A_OUT:   strobe.out_we  = 1'b1;
        A_CLR:   strobe.clr_we  = 1'b1;
        A_MASK:  strobe.mask_we = 1'b1;
        default: strobe = '0;
      endcase
    end
  end
endmodule

// File: rtl/sem_out_bank.sv
module sem_out_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         host_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] ack,
  output logic [W-1:0] flags
);
  logic [W-1:0] flags_q;
  logic [W-1:0] flags_d;

  always_comb begin
    if (host_we) flags_d = wdata;
    else         flags_d = flags_q & ~ack;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;

  p_host_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    host_we |=> (flags == $past(wdata)));

  p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_we && (|ack)) |=> ((flags & $past(ack)) == '0));

  p_reset_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (flags == '0));
endmodule

// File: rtl/sem_in_bank.sv
module sem_in_bank #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         clr_we,
  input  logic         mask_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] flags,
  output logic [W-1:0] mask,
  output logic         irq
);
  logic [W-1:0] flags_q;
  logic [W-1:0] mask_q;
  logic [W-1:0] live;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic kill;
    assign kill = clr_we & wdata[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags_q[i] <= 1'b0;
      else if (set[i]) flags_q[i] <= 1'b1;
      else if (kill)   flags_q[i] <= 1'b0;
    end
    assign live[i] = flags_q[i] & ~mask_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= wdata;
  end

  assign flags = flags_q;
  assign mask  = mask_q;
  assign irq   = |live;

  p_set_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((flags & $past(set)) == $past(set)));

  p_clear_works_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((flags & $past(wdata) & ~$past(set)) == '0));

  p_clear_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !(|set)) |=> ((flags & ~$past(wdata)) == ($past(flags) & ~$past(wdata))));

  p_set_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && (|(set & wdata))) |=> ((flags & $past(set & wdata)) == $past(set & wdata)));

  p_mask_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask == $past(wdata)));

  p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(|set) || $past(mask_we)));

  p_reset_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (flags == '0 && mask == '0 && !irq));
endmodule

// File: rtl/sem_irq_regs.sv
module sem_irq_regs
  import sem_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      cp_set,
  input  logic [W-1:0]      cp_ack,
  output logic [W-1:0]      cp_flags_o,
  output logic              host_irq
);
  localparam logic [W-1:0] STAT_IRQ = W'(1);

  wr_strobe_t   strobe;
  logic [W-1:0] out_flags;
  logic [W-1:0] in_flags;
  logic [W-1:0] in_mask;
  logic         irq;

  sem_decode u_decode (
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .strobe   (strobe)
  );

  sem_out_bank #(.W(W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .host_we (strobe.out_we),
    .wdata   (bus_wdata),
    .ack     (cp_ack),
    .flags   (out_flags)
  );

  sem_in_bank #(.W(W)) u_in (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (cp_set),
    .clr_we  (strobe.clr_we),
    .mask_we (strobe.mask_we),
    .wdata   (bus_wdata),
    .flags   (in_flags),
    .mask    (in_mask),
    .irq     (irq)
  );

  always_comb begin
    case (bus_addr)
      A_OUT:   bus_rdata = out_flags;
      A_IN:    bus_rdata = in_flags;
      A_MASK:  bus_rdata = in_mask;
      A_STAT:  bus_rdata = irq ? STAT_IRQ : '0;
      default: bus_rdata = '0;
    endcase
  end

  assign cp_flags_o = out_flags;
  assign host_irq   = irq;

  p_in_readonly_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_IN && !(|cp_set)) |=> $stable(in_flags));

  p_status_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_STAT) |-> (bus_rdata[W-1:1] == '0 && bus_rdata[0] == host_irq));

  p_write_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_OUT) |=> (cp_flags_o == $past(bus_wdata)));
endmodule

// File: tb/sem_irq_regs_tb.sv
module sem_irq_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [15:0] cp_set = '0;
  logic [15:0] cp_ack = '0;
  logic [15:0] cp_flags_o;
  logic        host_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sem_irq_regs dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .cp_set     (cp_set),
    .cp_ack     (cp_ack),
    .cp_flags_o (cp_flags_o),
    .host_irq   (host_irq)
  );

  typedef struct packed {
    logic        we;
    logic [2:0]  addr;
    logic [15:0] wdata;
    logic [15:0] set;
    logic [15:0] ack;
    logic [2:0]  raddr;
    logic [15:0] exp;
    logic        irq;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{we:1'b1, addr:3'd0, wdata:16'hA5A5, set:16'h0000, ack:16'h0000, raddr:3'd0, exp:16'hA5A5, irq:1'b0}, // R2
    '{we:1'b0, addr:3'd0, wdata:16'h0000, set:16'h0000, ack:16'h00FF, raddr:3'd0, exp:16'hA500, irq:1'b0}, // R3 ack
    '{we:1'b1, addr:3'd0, wdata:16'h1234, set:16'h0000, ack:16'hFFFF, raddr:3'd0, exp:16'h1234, irq:1'b0}, // R3 write wins
    '{we:1'b0, addr:3'd0, wdata:16'h0000, set:16'h0011, ack:16'h0000, raddr:3'd1, exp:16'h0011, irq:1'b1}, // R4 set, R7 irq
    '{we:1'b1, addr:3'd1, wdata:16'hFFFF, set:16'h0000, ack:16'h0000, raddr:3'd1, exp:16'h0011, irq:1'b1}, // R4 read only
    '{we:1'b1, addr:3'd3, wdata:16'h0011, set:16'h0000, ack:16'h0000, raddr:3'd4, exp:16'h0000, irq:1'b0}, // R7 masked, R8
    '{we:1'b1, addr:3'd3, wdata:16'h0010, set:16'h0000, ack:16'h0000, raddr:3'd4, exp:16'h0001, irq:1'b1}, // R8 status
    '{we:1'b1, addr:3'd2, wdata:16'h0001, set:16'h0000, ack:16'h0000, raddr:3'd1, exp:16'h0010, irq:1'b0}, // R5 clear
    '{we:1'b1, addr:3'd2, wdata:16'h0000, set:16'h0000, ack:16'h0000, raddr:3'd1, exp:16'h0010, irq:1'b0}, // R5 zero keeps
    '{we:1'b1, addr:3'd2, wdata:16'h0300, set:16'h0100, ack:16'h0000, raddr:3'd1, exp:16'h0110, irq:1'b1}, // R6 set wins
    '{we:1'b0, addr:3'd0, wdata:16'h0000, set:16'h0000, ack:16'h0000, raddr:3'd2, exp:16'h0000, irq:1'b1}, // R5 reads 0
    '{we:1'b0, addr:3'd0, wdata:16'h0000, set:16'h0000, ack:16'h0000, raddr:3'd7, exp:16'h0000, irq:1'b1}, // R8 unmapped
    '{we:1'b0, addr:3'd0, wdata:16'h0000, set:16'h0000, ack:16'h0000, raddr:3'd3, exp:16'h0010, irq:1'b1}  // R7 mask reads
  };

  task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    bus_we = v.we; bus_addr = v.addr; bus_wdata = v.wdata;
    cp_set = v.set; cp_ack = v.ack;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; cp_set = '0; cp_ack = '0; bus_addr = v.raddr;
    #1;
  endtask

  task automatic read_chk(input string req, input logic [2:0] a, input logic [15:0] exp);
    bus_addr = a;
    #1;
    check16(req, bus_rdata, exp);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    read_chk("R1 out", 3'd0, 16'h0000);
    read_chk("R1 in", 3'd1, 16'h0000);
    read_chk("R1 mask", 3'd3, 16'h0000);
    check16("R1 irq", {15'd0, host_irq}, 16'h0000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      check16($sformatf("vec%0d rdata", i), bus_rdata, VEC[i].exp);
      check16($sformatf("vec%0d irq R7", i), {15'd0, host_irq}, {15'd0, VEC[i].irq});
    end

    // R2 outward value on coprocessor pins
    apply('{we:1'b1, addr:3'd0, wdata:16'hBEEF, set:16'h0, ack:16'h0, raddr:3'd0, exp:16'h0, irq:1'b0});
    check16("R2 cp_flags_o", cp_flags_o, 16'hBEEF);

    // R7 unmasked all: irq follows clearing last live flag
    apply('{we:1'b1, addr:3'd3, wdata:16'h0000, set:16'h0, ack:16'h0, raddr:3'd1, exp:16'h0, irq:1'b0});
    apply('{we:1'b1, addr:3'd2, wdata:16'hFFFF, set:16'h0, ack:16'h0, raddr:3'd1, exp:16'h0, irq:1'b0});
    check16("R5 clear all", bus_rdata, 16'h0000);
    check16("R7 irq low", {15'd0, host_irq}, 16'h0000);

    // R1 reset mid-run
    apply('{we:1'b0, addr:3'd0, wdata:16'h0, set:16'h8001, ack:16'h0, raddr:3'd1, exp:16'h0, irq:1'b0});
    apply('{we:1'b1, addr:3'd3, wdata:16'h00F0, set:16'h0, ack:16'h0, raddr:3'd1, exp:16'h0, irq:1'b0});
    rst_n = 1'b0;
    #1;
    read_chk("R1 in after reset", 3'd1, 16'h0000);
    read_chk("R1 mask after reset", 3'd3, 16'h0000);
    check16("R1 cp_flags_o", cp_flags_o, 16'h0000);
    check16("R1 irq after reset", {15'd0, host_irq}, 16'h0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule